// File: doc/BRIEF.md
# Integer Shift and Logic Unit

This is a single-cycle 32-bit execution unit for the integer datapath of a processor core. It covers three groups of operations:

- bitwise logic on two words;
- single-word transforms: byte or halfword sign extension and leading-zero count;
- a bytewise equality mask, plus logical and algebraic shifts.

Each operation takes one word, or two, and returns a result word. The algebraic right shifts also return a carry flag, which is set when a negative value loses 1-bits. A separate carry-write-enable tells the flag logic downstream when that carry is meaningful.

An operation is issued by raising `in_valid` together with `op`, `src_a`, and either `src_b` or `shamt_imm`. The result, carry and carry-write-enable are registered, so they appear one clock later. `out_valid` marks the cycle in which they appear. Shift amounts taken from a register are six bits wide, so an amount from 32 to 63 flushes the whole word.

Top module: `shift_logic_unit`

## Requirements
- R1: Logic operations produce, from `src_a` (a) and `src_b` (b), using the following `op` codes: 0 a&b, 1 a|b, 2 a^b, 3 ~(a&b), 4 ~(a|b), 5 ~(a^b), 6 a&~b, 7 a|~b.
- R2: Op 8 sign-extends bits 7:0 of a to 32 bits. Op 9 sign-extends bits 15:0 of a.
- R3: Op 10 returns the number of leading zeros of a. This is 32 when a is zero, and otherwise 31 minus the index of the highest set bit.
- R4: Op 11 returns a mask. Each byte of the mask is 0xFF where the matching bytes of a and b are equal, and 0x00 where they differ.
- R5: Ops 12 (shift left) and 13 (logical shift right) take their amount from b[5:0] and ignore the other bits of b and `shamt_imm`. When b[5] is set the result is zero; otherwise a is shifted by b[4:0].
- R6: Op 14 (algebraic right shift by b[5:0]) fills with the sign bit. When b[5] is set it returns all ones for a negative a and zero otherwise. An amount of zero returns a unchanged.
- R7: For ops 14 and 15, carry is 1 only when a is negative and at least one 1-bit is shifted out. For an amount of 32 or more, the bits lost are a[30:0]. An amount of zero always gives carry 0.
- R8: Op 15 (algebraic right shift immediate) shifts by `shamt_imm` and ignores b. An immediate of zero returns a unchanged with carry 0.
- R9: `carry_we` is 1 for a valid op 14 or op 15 and 0 for every other op. `carry` is 0 whenever `carry_we` is 0.
- R10: Result, carry and `carry_we` appear on the clock edge after the issuing edge, and `out_valid` is `in_valid` delayed by one cycle.
- R11: A cycle without `in_valid` leaves `result` unchanged and clears `carry`, `carry_we` and `out_valid`.
- R12: While reset is held, `out_valid`, `result`, `carry` and `carry_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe |
| op | input | 4 | Operation select (codes in R1–R8) |
| src_a | input | 32 | Source word |
| src_b | input | 32 | Second word or register shift amount |
| shamt_imm | input | 5 | Immediate shift amount for op 15 |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 32 | Result word |
| carry | output | 1 | Carry from an algebraic right shift |
| carry_we | output | 1 | Carry is to be written |

## Verification
The assertions check the cycle-level rules on every cycle:
- the one-cycle valid pipeline;
- the result holding while idle;
- `carry_we` staying low for non-shift ops;
- carry never rising without `carry_we` or for a non-negative source;
- the flush to zero on logical shifts with bit 5 set;
- the count of 32 for a zero input.

Only the bench's scenarios can show the computed values: each logic function, the sign-extension boundaries, the per-byte mask, exact shift results and which lost bits set carry.

// File: rtl/slu_pkg.sv
package slu_pkg;

    typedef enum logic [3:0] {
        OP_AND    = 4'd0,
        OP_OR     = 4'd1,
        OP_XOR    = 4'd2,
        OP_NAND   = 4'd3,
        OP_NOR    = 4'd4,
        OP_EQV    = 4'd5,
        OP_ANDC   = 4'd6,
        OP_ORC    = 4'd7,
        OP_SEXT8  = 4'd8,
        OP_SEXT16 = 4'd9,
        OP_CLZ    = 4'd10,
        OP_BYTEEQ = 4'd11,
        OP_SHL    = 4'd12,
        OP_SHR    = 4'd13,
        OP_SAR    = 4'd14,
        OP_SARI   = 4'd15
    } slu_op_e;

    function automatic logic is_shift(slu_op_e op);
        return op inside {OP_SHL, OP_SHR, OP_SAR, OP_SARI};
    endfunction

    function automatic logic is_alg_shift(slu_op_e op);
        return op inside {OP_SAR, OP_SARI};
    endfunction

endpackage

// File: rtl/slu_logic.sv
module slu_logic
    import slu_pkg::*;
#(
    parameter int W = 32
) (
    input  slu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int NBYTES = W / 8;
    localparam int CW     = $clog2(W + 1);

    logic [W-1:0]  byte_mask;
    logic [CW-1:0] lz_cnt;

    // one 8-bit comparator per byte lane
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign byte_mask[g*8 +: 8] = (a[g*8 +: 8] == b[g*8 +: 8]) ? 8'hFF : 8'h00;
    end

    // scan from the low end: the last set bit seen is the highest one
    always_comb begin
        lz_cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a[i]) lz_cnt = CW'(W - 1 - i);
        end
    end

    always_comb begin
        unique case (op)
            OP_AND:    y = a & b;
            OP_OR:     y = a | b;
            OP_XOR:    y = a ^ b;
            OP_NAND:   y = ~(a & b);
            OP_NOR:    y = ~(a | b);
            OP_EQV:    y = ~(a ^ b);
            OP_ANDC:   y = a & ~b;
            OP_ORC:    y = a | ~b;
            OP_SEXT8:  y = {{(W-8){a[7]}}, a[7:0]};
            OP_SEXT16: y = {{(W-16){a[15]}}, a[15:0]};
            OP_CLZ:    y = {{(W-CW){1'b0}}, lz_cnt};
            OP_BYTEEQ: y = byte_mask;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/slu_shift.sv
module slu_shift
    import slu_pkg::*;
#(
    parameter int W = 32
) (
    input  slu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [SW-1:0]    imm,
    output logic [W-1:0]     y,
    output logic             carry
);
    localparam int SW = $clog2(W);

    logic [SW:0]   amt;
    logic          flush;
    logic [SW-1:0] sh;
    logic [W-1:0]  lost_mask;
    logic          neg;

    always_comb begin
        amt   = (op == OP_SARI) ? {1'b0, imm} : b[SW:0];
        flush = amt[SW];
        sh    = amt[SW-1:0];
        neg   = a[W-1];
        // bits that leave the word; a full flush loses everything below the sign
        lost_mask = flush ? {1'b0, {(W-1){1'b1}}} : ~({W{1'b1}} << sh);

        unique case (op)
            OP_SHL:  y = flush ? '0 : (a << sh);
            OP_SHR:  y = flush ? '0 : (a >> sh);
            OP_SAR,
            OP_SARI: y = flush ? {W{neg}} : $unsigned($signed(a) >>> sh);
            default: y = '0;
        endcase

        carry = is_alg_shift(op) && neg && (|(a & lost_mask));
    end
endmodule

// File: rtl/shift_logic_unit.sv
module shift_logic_unit
    import slu_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [SW-1:0] shamt_imm,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic          carry,
    output logic          carry_we
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] res;
        logic         carry;
        logic         cwe;
    } out_s;

    slu_op_e      op_e;
    logic [W-1:0] logic_y;
    logic [W-1:0] shift_y;
    logic         shift_c;
    out_s         st_d, st_q;

    assign op_e = slu_op_e'(op);

    slu_logic #(.W(W)) u_logic (
        .op (op_e),
        .a  (src_a),
        .b  (src_b),
        .y  (logic_y)
    );

    slu_shift #(.W(W)) u_shift (
        .op    (op_e),
        .a     (src_a),
        .b     (src_b),
        .imm   (shamt_imm),
        .y     (shift_y),
        .carry (shift_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.carry = 1'b0;
        st_d.cwe   = 1'b0;
        if (in_valid) begin
            st_d.res   = is_shift(op_e) ? shift_y : logic_y;
            st_d.carry = is_alg_shift(op_e) && shift_c;
            st_d.cwe   = is_alg_shift(op_e);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign carry     = st_q.carry;
    assign carry_we  = st_q.cwe;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !carry_we && $stable(result)));

    // R9
    cwe_only_alg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(op inside {4'd14, 4'd15})) |=> !carry_we);

    // R9
    carry_needs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> carry_we);

    // R7
    carry_needs_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !src_a[W-1]) |=> !carry);

    // R5
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op inside {4'd12, 4'd13}) && src_b[SW]) |=> (result == '0));

    // R3
    clz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd10 && src_a == '0) |=> (result == W));
endmodule

// File: tb/tb_shift_logic_unit.sv
module tb_shift_logic_unit;
    import slu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] src_a, src_b;
    logic [4:0]  shamt_imm;
    logic        out_valid, carry, carry_we;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    shift_logic_unit dut (
        .clk, .rst_n, .in_valid, .op, .src_a, .src_b, .shamt_imm,
        .out_valid, .result, .carry, .carry_we
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  imm;
        logic [31:0] res;
        logic        c;
        logic        we;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0,  32'h00F0_1234, 1'b0, 1'b0}, // R1
        '{4'd1,  32'hF000_0000, 32'h0000_000F, 5'd0,  32'hF000_000F, 1'b0, 1'b0}, // R1
        '{4'd2,  32'hFFFF_0000, 32'h0F0F_0F0F, 5'd0,  32'hF0F0_0F0F, 1'b0, 1'b0}, // R1
        '{4'd3,  32'hFFFF_0000, 32'hFF00_FF00, 5'd0,  32'h00FF_FFFF, 1'b0, 1'b0}, // R1
        '{4'd4,  32'hF000_0000, 32'h0000_000F, 5'd0,  32'h0FFF_FFF0, 1'b0, 1'b0}, // R1
        '{4'd5,  32'hAAAA_AAAA, 32'hAAAA_5555, 5'd0,  32'hFFFF_0000, 1'b0, 1'b0}, // R1
        '{4'd6,  32'hFFFF_FFFF, 32'h0000_FFFF, 5'd0,  32'hFFFF_0000, 1'b0, 1'b0}, // R1
        '{4'd7,  32'h0000_0000, 32'hFFFF_0000, 5'd0,  32'h0000_FFFF, 1'b0, 1'b0}, // R1
        '{4'd8,  32'h1234_5680, 32'h0,         5'd0,  32'hFFFF_FF80, 1'b0, 1'b0}, // R2
        '{4'd8,  32'hFFFF_FF7F, 32'h0,         5'd0,  32'h0000_007F, 1'b0, 1'b0}, // R2
        '{4'd9,  32'h0000_8001, 32'h0,         5'd0,  32'hFFFF_8001, 1'b0, 1'b0}, // R2
        '{4'd10, 32'h0000_0000, 32'h0,         5'd0,  32'd32,        1'b0, 1'b0}, // R3
        '{4'd10, 32'h0001_0000, 32'h0,         5'd0,  32'd15,        1'b0, 1'b0}, // R3
        '{4'd10, 32'h8000_0000, 32'h0,         5'd0,  32'd0,         1'b0, 1'b0}, // R3
        '{4'd11, 32'h1122_3344, 32'h1100_3355, 5'd0,  32'hFF00_FF00, 1'b0, 1'b0}, // R4
        '{4'd12, 32'h0000_0001, 32'h0000_001F, 5'd5,  32'h8000_0000, 1'b0, 1'b0}, // R5
        '{4'd12, 32'hFFFF_FFFF, 32'h0000_0020, 5'd0,  32'h0000_0000, 1'b0, 1'b0}, // R5
        '{4'd12, 32'h0000_0001, 32'h0000_0041, 5'd0,  32'h0000_0002, 1'b0, 1'b0}, // R5
        '{4'd13, 32'h8000_0000, 32'h0000_0004, 5'd9,  32'h0800_0000, 1'b0, 1'b0}, // R5
        '{4'd13, 32'hFFFF_FFFF, 32'h0000_003F, 5'd0,  32'h0000_0000, 1'b0, 1'b0}, // R5
        '{4'd14, 32'h8000_0000, 32'h0000_0004, 5'd0,  32'hF800_0000, 1'b0, 1'b1}, // R6
        '{4'd14, 32'h8000_0001, 32'h0000_0001, 5'd0,  32'hC000_0000, 1'b1, 1'b1}, // R7
        '{4'd14, 32'h7FFF_FFFF, 32'h0000_0008, 5'd0,  32'h007F_FFFF, 1'b0, 1'b1}, // R7
        '{4'd14, 32'hFFFF_FFF0, 32'h0000_0020, 5'd0,  32'hFFFF_FFFF, 1'b1, 1'b1}, // R6
        '{4'd14, 32'h8000_0000, 32'h0000_0025, 5'd0,  32'hFFFF_FFFF, 1'b0, 1'b1}, // R7
        '{4'd14, 32'h1234_5678, 32'h0000_0030, 5'd0,  32'h0000_0000, 1'b0, 1'b1}, // R6
        '{4'd14, 32'h8000_0001, 32'h0000_0000, 5'd0,  32'h8000_0001, 1'b0, 1'b1}, // R6
        '{4'd15, 32'hFFFF_FFFF, 32'h0000_0000, 5'd0,  32'hFFFF_FFFF, 1'b0, 1'b1}, // R8
        '{4'd15, 32'hFFFF_FF01, 32'h0000_0000, 5'd4,  32'hFFFF_FFF0, 1'b1, 1'b1}, // R7
        '{4'd15, 32'h8000_0000, 32'h0000_0000, 5'd31, 32'hFFFF_FFFF, 1'b0, 1'b1}, // R7
        '{4'd15, 32'h8000_0010, 32'h0000_0000, 5'd5,  32'hFC00_0000, 1'b1, 1'b1}, // R7
        '{4'd15, 32'h0000_0100, 32'hFFFF_FFFF, 5'd4,  32'h0000_0010, 1'b0, 1'b1}  // R8
    };

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [3:0] o, logic [31:0] a, logic [31:0] b, logic [4:0] imm);
        @(negedge clk);
        in_valid  = 1'b1;
        op        = o;
        src_a     = a;
        src_b     = b;
        shamt_imm = imm;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op = '0;
        src_a = '0; src_b = '0; shamt_imm = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "out_valid", {31'b0, out_valid}, 32'd0);
        check("R12", "result",    result,             32'd0);
        check("R12", "carry",     {31'b0, carry},     32'd0);
        check("R12", "carry_we",  {31'b0, carry_we},  32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].imm);
            // R10: values registered on the edge after issue
            check("R10", "out_valid", {31'b0, out_valid}, 32'd1);
            check($sformatf("vec%0d", i), "result",   result,            VEC[i].res);
            check($sformatf("vec%0d", i), "carry",    {31'b0, carry},    {31'b0, VEC[i].c});
            // R9
            check("R9", "carry_we", {31'b0, carry_we}, {31'b0, VEC[i].we});
        end

        // R11: idle cycle with changed inputs keeps result, clears flags
        issue(4'd15, 32'h8000_0010, 32'h0, 5'd5);
        @(negedge clk);
        in_valid = 1'b0; op = 4'd2; src_a = 32'h1234_5678; src_b = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R11", "result",    result,             32'hFC00_0000);
        check("R11", "out_valid", {31'b0, out_valid}, 32'd0);
        check("R11", "carry",     {31'b0, carry},     32'd0);
        check("R11", "carry_we",  {31'b0, carry_we},  32'd0);

        // R10: back-to-back issue, each result one cycle later
        @(negedge clk);
        in_valid = 1'b1; op = 4'd0; src_a = 32'hFFFF_FFFF; src_b = 32'h0000_00AA;
        @(negedge clk);
        check("R10", "b2b first", result, 32'h0000_00AA);
        op = 4'd10; src_a = 32'h0000_0001;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", "b2b second", result, 32'd31);

        // R12: reset mid-run clears the outputs
        issue(4'd14, 32'h8000_0001, 32'h1, 5'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", "result after reset", result, 32'd0);
        check("R12", "carry after reset",  {31'b0, carry}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule